// File: doc/BRIEF.md
# Phase-Steppable Output Clock Divider

This block produces a divided output clock from a fast tick input. Each tick stands for one 45-degree slot of the oscillator period, so eight ticks make one oscillator cycle. The output runs at the oscillator rate divided by (divide field + 1) with a 50% duty cycle. Software can also move the output edges earlier by whole 45-degree slots.

Software reaches the block through one 32-bit register with a write strobe and a read bus that is always valid. The register holds a 9-bit divide field and a 12-bit step field. Software loads a step count, and hardware counts that field down by one on every tick while it applies the steps. Software polls the field until it reads zero to learn that the shift is complete.

Two control inputs come from a neighbouring register. The divider-reset input restarts the output sequence. The align input zeroes the accumulated-shift tracker, so later shifts are measured from a known origin. A 3-bit accumulated-shift output (modulo 8 slots) lets the environment compare the measured edge offset with the total steps requested.

Top module: `pdiv_phase_clkgen`

## Requirements
- R1: The divide field is register bits 8:0. With value D the output period is 8*(D+1) ticks, and the output is high for the first 4*(D+1) ticks of each period.
- R2: After cold reset the register reads 0x00000001, so the divide field is 1 and the step field is 0. The output is low during reset and then runs with a 16-tick period.
- R3: The step field is register bits 20:9. A write loads it only when it currently reads zero. A write while it is nonzero leaves it unchanged. The divide field takes every write.
- R4: While the step field is nonzero and the output sequence is running, it drops by exactly one per tick. A load of N therefore reads zero N ticks after the write tick.
- R5: Each applied step makes the output sequence advance two positions on that tick, so all later rising edges arrive one tick earlier. Each step also adds one, modulo 8, to the accumulated-shift output.
- R6: A new divide value takes effect at the next period boundary. No high or low run is shorter than the old or the new half-period.
- R7: While divider-reset is high, the output is low, the accumulated shift is 0, and the step field is frozen. The first tick after release starts a full high half-period.
- R8: A one-tick pulse on the align input zeroes the accumulated-shift output. It does not disturb the output period or the edge positions.
- R9: A warm reset stops and restarts the output sequence but keeps both register fields.
- R10: Bits 31:21 always read zero, and write data in those bits has no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick, one 45-degree slot per cycle |
| cold_rst_n | input | 1 | Active-low cold reset for register fields and datapath |
| warm_rst_n | input | 1 | Active-low warm reset for the datapath only |
| div_rst | input | 1 | Divider reset from the neighbouring control register |
| phase_align | input | 1 | Zeroes the accumulated-shift tracker |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| clk_out | output | 1 | Divided, phase-steppable output clock |
| phase_acc | output | 3 | Accumulated steps since divider reset or align, modulo 8 |

## Verification
The divider is run with divide values 0, 1, 4 and 511. This separates the +1 offset and the slot scaling from off-by-one errors, and the largest value exposes truncation in the position counter. Shifts of 3 and then 6 steps are measured as rising-edge offsets from an edge taken right after a divider reset. Their total of 9 wraps past 8 slots in the tracker but not in the 16-tick period, which separates a wrong advance size from a wrong modulo. A divide change issued in mid high phase, a second write during a long countdown, a step load made together with a divider reset, and a warm reset on a nonzero divide value each test one ordering rule.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    localparam int unsigned REG_W = 32;

    typedef enum logic {
        PD_HALT = 1'b0,
        PD_RUN  = 1'b1
    } pd_run_e;

    // Length in ticks of one output period for divide value d
    function automatic int unsigned pd_period(input int unsigned d, input int unsigned slot_log2);
        return (d + 1) << slot_log2;
    endfunction
endpackage

// File: rtl/pdiv_regs.sv
module pdiv_regs
    import pdiv_pkg::*;
#(
    parameter int unsigned DIV_W       = 9,
    parameter int unsigned PH_W        = 12,
    parameter int unsigned DIV_RST_VAL = 1
) (
    input  logic             clk,
    input  logic             cold_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             step_ok,
    output logic [REG_W-1:0] rd_data,
    output logic [DIV_W-1:0] div_field,
    output logic             step
);
    localparam int unsigned PH_LSB = DIV_W;
    localparam int unsigned RSV_W  = REG_W - DIV_W - PH_W;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PH_W-1:0]  ph;
    } regs_t;

    regs_t r_d, r_q;
    logic  ph_idle;

    assign ph_idle = (r_q.ph == '0);
    assign step    = !ph_idle && step_ok;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.div = wr_data[DIV_W-1:0];
        end
        if (wr_en && ph_idle) begin
            r_d.ph = wr_data[PH_LSB +: PH_W];
        end else if (step) begin
            r_d.ph = r_q.ph - PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n) begin
            r_q.div <= DIV_W'(DIV_RST_VAL);
            r_q.ph  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data   = {{RSV_W{1'b0}}, r_q.ph, r_q.div};
    assign div_field = r_q.div;
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core
    import pdiv_pkg::*;
#(
    parameter int unsigned DIV_W       = 9,
    parameter int unsigned SLOT_LOG2   = 3,
    parameter int unsigned DIV_RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_rst,
    input  logic             step,
    input  logic [DIV_W-1:0] div_field,
    output logic             step_ok,
    output logic             clk_out
);
    localparam int unsigned PW = DIV_W + 1 + SLOT_LOG2;

    typedef struct packed {
        pd_run_e          run;
        logic [DIV_W-1:0] act;
        logic [PW-1:0]    pos;
        logic             out;
    } core_t;

    core_t         c_d, c_q;
    logic [PW-1:0] period_cur;
    logic [PW-1:0] sum;
    logic [PW-1:0] half_nxt;

    assign step_ok    = (c_q.run == PD_RUN) && !div_rst;
    assign period_cur = PW'(pd_period(int'(c_q.act), SLOT_LOG2));

    always_comb begin
        c_d      = c_q;
        sum      = c_q.pos + (step ? PW'(2) : PW'(1));
        half_nxt = '0;
        if (div_rst) begin
            c_d.run = PD_HALT;
            c_d.pos = '0;
            c_d.act = div_field;
            c_d.out = 1'b0;
        end else if (c_q.run == PD_HALT) begin
            c_d.run = PD_RUN;
            c_d.pos = '0;
            c_d.act = div_field;
            c_d.out = 1'b1;
        end else begin
            if (sum >= period_cur) begin
                c_d.pos = sum - period_cur;
                c_d.act = div_field;
            end else begin
                c_d.pos = sum;
            end
            half_nxt = PW'(pd_period(int'(c_d.act), SLOT_LOG2) >> 1);
            c_d.out  = (c_d.pos < half_nxt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.run <= PD_HALT;
            c_q.act <= DIV_W'(DIV_RST_VAL);
            c_q.pos <= '0;
            c_q.out <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign clk_out = c_q.out;
endmodule

// File: rtl/pdiv_phase_acc.sv
module pdiv_phase_acc #(
    parameter int unsigned SLOT_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 step,
    output logic [SLOT_LOG2-1:0] acc
);
    logic [SLOT_LOG2-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (step) begin
            acc_d = acc_q + SLOT_LOG2'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;
endmodule

// File: rtl/pdiv_phase_clkgen.sv
module pdiv_phase_clkgen
    import pdiv_pkg::*;
#(
    parameter int unsigned DIV_W       = 9,
    parameter int unsigned PH_W        = 12,
    parameter int unsigned SLOT_LOG2   = 3,
    parameter int unsigned DIV_RST_VAL = 1
) (
    input  logic                 clk,
    input  logic                 cold_rst_n,
    input  logic                 warm_rst_n,
    input  logic                 div_rst,
    input  logic                 phase_align,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    output logic                 clk_out,
    output logic [SLOT_LOG2-1:0] phase_acc
);
    logic             dp_rst_n;
    logic             step_ok;
    logic             step;
    logic [DIV_W-1:0] div_field;

    assign dp_rst_n = cold_rst_n & warm_rst_n;

    pdiv_regs #(
        .DIV_W      (DIV_W),
        .PH_W       (PH_W),
        .DIV_RST_VAL(DIV_RST_VAL)
    ) u_regs (
        .clk       (clk),
        .cold_rst_n(cold_rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .step_ok   (step_ok),
        .rd_data   (rd_data),
        .div_field (div_field),
        .step      (step)
    );

    pdiv_core #(
        .DIV_W      (DIV_W),
        .SLOT_LOG2  (SLOT_LOG2),
        .DIV_RST_VAL(DIV_RST_VAL)
    ) u_core (
        .clk      (clk),
        .rst_n    (dp_rst_n),
        .div_rst  (div_rst),
        .step     (step),
        .div_field(div_field),
        .step_ok  (step_ok),
        .clk_out  (clk_out)
    );

    pdiv_phase_acc #(
        .SLOT_LOG2(SLOT_LOG2)
    ) u_acc (
        .clk  (clk),
        .rst_n(dp_rst_n),
        .clear(div_rst | phase_align),
        .step (step),
        .acc  (phase_acc)
    );
endmodule

// File: rtl/pdiv_checker.sv
module pdiv_checker
    import pdiv_pkg::*;
#(
    parameter int unsigned DIV_W     = 9,
    parameter int unsigned PH_W      = 12,
    parameter int unsigned SLOT_LOG2 = 3
) (
    input logic                 clk,
    input logic                 cold_rst_n,
    input logic                 warm_rst_n,
    input logic                 div_rst,
    input logic                 phase_align,
    input logic                 wr_en,
    input logic [REG_W-1:0]     wr_data,
    input logic [REG_W-1:0]     rd_data,
    input logic                 clk_out,
    input logic [SLOT_LOG2-1:0] phase_acc
);
    logic [PH_W-1:0] ph;
    assign ph = rd_data[DIV_W +: PH_W];

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!cold_rst_n)
        rd_data[REG_W-1:DIV_W+PH_W] == '0); // R10

    AST_DIV_WRITE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        wr_en |=> rd_data[DIV_W-1:0] == $past(wr_data[DIV_W-1:0])); // R3

    AST_PH_LOAD: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (wr_en && ph == '0) |=> ph == $past(wr_data[DIV_W +: PH_W])); // R3

    AST_PH_NO_RISE: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (ph != '0) |=> ph <= $past(ph)); // R3

    AST_PH_ONE_STEP: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (ph != '0) |=> ph >= ($past(ph) - PH_W'(1))); // R4

    AST_PH_FROZEN: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (ph != '0 && (div_rst || !warm_rst_n)) |=> ph == $past(ph)); // R7

    AST_DIVRST_LOW: assert property (@(posedge clk) disable iff (!cold_rst_n)
        div_rst |=> !clk_out); // R7

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (div_rst || phase_align) |=> phase_acc == '0); // R8

    AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!warm_rst_n && !wr_en) |=> $stable(rd_data)); // R9
endmodule

bind pdiv_phase_clkgen pdiv_checker #(
    .DIV_W    (DIV_W),
    .PH_W     (PH_W),
    .SLOT_LOG2(SLOT_LOG2)
) u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .warm_rst_n (warm_rst_n),
    .div_rst    (div_rst),
    .phase_align(phase_align),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .clk_out    (clk_out),
    .phase_acc  (phase_acc)
);

// File: tb/tb_pdiv_phase_clkgen.sv
`timescale 1ns/1ps
module tb_pdiv_phase_clkgen;
    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        div_rst = 1'b0;
    logic        phase_align = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_out;
    logic [2:0]  phase_acc;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    pdiv_phase_clkgen dut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .div_rst(div_rst), .phase_align(phase_align), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .clk_out(clk_out),
        .phase_acc(phase_acc)
    );

    // Edge monitor, runs on the falling clock edge
    int   cyc = 0, rises = 0, falls = 0;
    int   last_rise = 0, prev_rise = 0, last_fall = 0, hi_len = 0;
    logic prev_out = 1'b0;
    logic win = 1'b0, bad_run = 1'b0;
    int   ok_a = 0, ok_b = 0;

    always @(negedge clk) begin
        cyc++;
        if (clk_out && !prev_out) begin
            if (win && (cyc - last_fall) != ok_a && (cyc - last_fall) != ok_b) bad_run = 1'b1;
            prev_rise = last_rise;
            last_rise = cyc;
            rises++;
        end
        if (!clk_out && prev_out) begin
            hi_len = cyc - last_rise;
            if (win && hi_len != ok_a && hi_len != ok_b) bad_run = 1'b1;
            last_fall = cyc;
            falls++;
        end
        prev_out = clk_out;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        wr_en = 1'b1;
        wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic wait_rises(input int n);
        int tgt;
        tgt = rises + n;
        while (rises < tgt) tick();
    endtask

    task automatic wait_falls(input int n);
        int tgt;
        tgt = falls + n;
        while (falls < tgt) tick();
    endtask

    task automatic wait_ph_zero();
        while (rd_data[20:9] != 0) tick();
    endtask

    task automatic measure(output int per, output int hi);
        wait_rises(1);
        per = last_rise - prev_rise;
        wait_falls(1);
        hi = hi_len;
    endtask

    int t0 = 0;

    task automatic t_reset();
        int per, hi;
        check(clk_out == 1'b0, "R2 out low in reset", clk_out, 0);
        repeat (3) tick();
        cold_rst_n = 1'b1;
        tick();
        check(rd_data == 32'h1, "R2 reset value", rd_data, 1);
        wait_rises(1);
        measure(per, hi);
        check(per == 16, "R2 default period", per, 16);
    endtask

    task automatic t_reserved();
        wr(32'hFFE0_0002);
        check(rd_data == 32'h2, "R10 reserved bits ignored", rd_data, 2);
        wr(32'hFFE0_0001);
        check(rd_data[31:21] == 0, "R10 reserved read zero", rd_data[31:21], 0);
    endtask

    task automatic t_divide(input int d);
        int per, hi;
        wr(32'(d));
        wait_rises(2);
        measure(per, hi);
        check(per == 8 * (d + 1), "R1 period", per, 8 * (d + 1));
        check(hi == 4 * (d + 1), "R1 high time", hi, 4 * (d + 1));
    endtask

    task automatic t_load_rule();
        wr_en = 1'b1;
        wr_data = {11'b0, 12'd100, 9'd1};
        tick();
        wr_data = {11'b0, 12'd5, 9'd1};
        tick();
        wr_en = 1'b0;
        tick();
        check(rd_data[20:9] == 98, "R3 nonzero write ignored", rd_data[20:9], 98);
        wait_ph_zero();
        check(rd_data[20:9] == 0, "R3 field drains", rd_data[20:9], 0);
    endtask

    task automatic t_countdown();
        int k;
        wr({11'b0, 12'd10, 9'd1});
        check(rd_data[20:9] == 10, "R4 loaded count", rd_data[20:9], 10);
        k = 0;
        while (rd_data[20:9] != 0 && k < 100) begin
            tick();
            k++;
        end
        check(k == 10, "R4 countdown ticks", k, 10);
    endtask

    task automatic t_div_rst();
        wr_en = 1'b1;
        wr_data = {11'b0, 12'd20, 9'd1};
        div_rst = 1'b1;
        tick();
        wr_en = 1'b0;
        repeat (3) tick();
        check(rd_data[20:9] == 20, "R7 steps frozen", rd_data[20:9], 20);
        check(clk_out == 1'b0, "R7 output low", clk_out, 0);
        check(phase_acc == 0, "R7 accumulator clear", phase_acc, 0);
        div_rst = 1'b0;
        tick();
        check(clk_out == 1'b1, "R7 restart high", clk_out, 1);
        wait_ph_zero();
    endtask

    task automatic t_phase_shift();
        div_rst = 1'b1;
        repeat (2) tick();
        div_rst = 1'b0;
        wait_rises(1);
        t0 = last_rise;
        wr({11'b0, 12'd3, 9'd1});
        wait_ph_zero();
        wait_rises(2);
        check(((last_rise - t0) % 16) == 13, "R5 offset after 3", (last_rise - t0) % 16, 13);
        check(phase_acc == 3, "R5 accumulator 3", phase_acc, 3);
        wr({11'b0, 12'd6, 9'd1});
        wait_ph_zero();
        wait_rises(2);
        check(((last_rise - t0) % 16) == 7, "R5 offset after 9", (last_rise - t0) % 16, 7);
        check(phase_acc == 1, "R5 accumulator wraps", phase_acc, 1);
    endtask

    task automatic t_align();
        int per, hi;
        phase_align = 1'b1;
        tick();
        phase_align = 1'b0;
        check(phase_acc == 0, "R8 align clears", phase_acc, 0);
        measure(per, hi);
        check(per == 16, "R8 period kept", per, 16);
        check(((last_rise - t0) % 16) == 7, "R8 edges kept", (last_rise - t0) % 16, 7);
    endtask

    task automatic t_div_change();
        int per, hi;
        wait_rises(1);
        repeat (3) tick();
        ok_a = 8;
        ok_b = 16;
        bad_run = 1'b0;
        win = 1'b1;
        wr(32'd3);
        wait_rises(4);
        win = 1'b0;
        check(!bad_run, "R6 no runt run", bad_run, 0);
        measure(per, hi);
        check(per == 32, "R6 new period", per, 32);
    endtask

    task automatic t_warm();
        int per, hi;
        wr(32'd2);
        warm_rst_n = 1'b0;
        repeat (3) tick();
        check(rd_data == 32'd2, "R9 fields kept", rd_data, 2);
        check(clk_out == 1'b0, "R9 output stopped", clk_out, 0);
        warm_rst_n = 1'b1;
        wait_rises(2);
        measure(per, hi);
        check(per == 24, "R9 restart period", per, 24);
    endtask

    initial begin
        t_reset();
        t_reserved();
        t_divide(0);
        t_divide(4);
        t_divide(511);
        t_divide(1);
        t_load_rule();
        t_countdown();
        t_div_rst();
        t_phase_shift();
        t_align();
        t_div_change();
        t_warm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule